// File: doc/BRIEF.md
# Cache Maintenance Command Decoder

This block sits between the coprocessor transfer path of a processor core and the level-one cache controller. Each request aims at the cache-maintenance register group and carries an opcode1 field, a CRm field, an opcode2 field and a read/write flag. A flag marks two-register transfers, which carry a start and an end address. The decoder judges each request against the current privilege level and security world. It also takes a configuration input that says whether cache lockdown entries are reserved for the secure world.

For every request the decoder returns one of two outcomes, one cycle later:
- one strobe that names the maintenance, barrier, translation or register-access action, or
- the undefined-exception flag.

With a strobe it also gives a tag that says how the data word must be read: set/index, MVA, VA or SBZ. Whole-instruction-cache and both-cache invalidations also raise a global branch-target-cache flush. The decoder does not perform the cache actions or the address translations. It only names them.

Top module: `cmo_decoder`

## Requirements
- R1: Outputs are registered. A request with `req_valid` high in one cycle yields exactly one of these after the next rising edge: one bit of `op_strobe`, or `op_undef`. A cycle without a request yields all-zero outputs after that edge.
- R2: Any nonzero `req_op1` raises `op_undef`.
- R3: Single-register writes (CRm,opcode2) map to `op_strobe` bits as follows:
  - CRm 0, opcode2 4: bit 19, wait for interrupt.
  - CRm 4, opcode2 0: bit 20, physical-address register write.
  - CRm 5, opcode2 0, 1, 2, 4, 6, 7: bits 0, 1, 2, 3, 4, 5. These are instruction invalidate all/MVA/index, prefetch-buffer flush, branch-target flush all, and branch-target flush by MVA.
  - CRm 6, opcode2 0, 1, 2: bits 6, 7, 8, data invalidate.
  - CRm 7, opcode2 0: bit 9, invalidate both caches.
  - CRm 8, opcode2 0 to 3: bit 21, translation in the current world.
  - CRm 8, opcode2 4 to 7: bit 22, translation in the other world.
  - CRm 10, opcode2 0, 1, 2: bits 10, 11, 12, data clean.
  - CRm 10, opcode2 4: bit 13, synchronization barrier.
  - CRm 10, opcode2 5: bit 14, memory barrier.
  - CRm 13, opcode2 1: bit 15, instruction prefetch.
  - CRm 14, opcode2 0, 1, 2: bits 16, 17, 18, data clean-and-invalidate.
- R4: The following writes assert bit 29, the no-effect strobe, and do not raise an exception: CRm 7 with opcode2 1 to 7, and CRm 11 or 15 with any opcode2.
- R5: Every single-register write encoding not listed in R3 or R4 raises `op_undef`. This includes CRm 10 with opcode2 6.
- R6: Reads are legal only for CRm 10 with opcode2 6, which gives bit 23 (dirty status), and for CRm 4 with opcode2 0, which gives bit 24 (physical-address register). Any other read raises `op_undef`.
- R7: With `req_user` high, only these are accepted: the synchronization barrier, the memory barrier, the prefetch-buffer flush, and the clean-data range. Every other request raises `op_undef`.
- R8: With `req_nonsecure` high, whole-data-cache invalidate (CRm 6, opcode2 0) and both-cache invalidate (CRm 7, opcode2 0) raise `op_undef`.
- R9: With `req_nonsecure` high, whole-instruction-cache invalidate raises `op_undef` when `cfg_lock_secure` is 1. When `cfg_lock_secure` is 0, it is accepted as bit 0.
- R10: Other-world translation (CRm 8, opcode2 4 to 7) raises `op_undef` in the non-secure world and in user mode.
- R11: Two-register writes decode CRm alone:
  - CRm 5: bit 25, instruction range invalidate.
  - CRm 6: bit 26, data range invalidate.
  - CRm 12: bit 27, data range clean.
  - CRm 14: bit 28, data range clean-and-invalidate.

  Any other CRm gives bit 29, the no-effect strobe. A two-register request with the read flag set raises `op_undef`.
- R12: `op_btc_flush` is high together with bit 0 or bit 9 and at no other time.
- R13: `op_fmt` is 1 (MVA) for bits 1, 5, 7, 11, 15 and 17. It is 2 (set/index) for bits 2, 8, 12 and 18. It is 3 (VA) for bits 21, 22 and 25 to 28. It is 0 (SBZ) for every other outcome, including `op_undef`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op1 | input | 3 | Opcode1 field |
| req_crm | input | 4 | CRm field |
| req_op2 | input | 3 | Opcode2 field |
| req_is_read | input | 1 | 1 for a register read, 0 for a write |
| req_dual | input | 1 | Two-register (range) transfer |
| req_user | input | 1 | Request issued in user mode |
| req_nonsecure | input | 1 | Request issued in the non-secure world |
| cfg_lock_secure | input | 1 | Lockdown entries are reserved for the secure world |
| op_strobe | output | 30 | One-hot action strobe |
| op_fmt | output | 2 | Data-word format tag |
| op_undef | output | 1 | Undefined-exception flag |
| op_btc_flush | output | 1 | Global branch-target-cache flush |

## Verification
The properties assume that each request's fields are stable in the cycle where `req_valid` is high. They also assume that `cfg_lock_secure` changes only while no request is present. Fields sampled while `req_valid` is low may hold any value. The bench drives each request for exactly one cycle on the falling edge and returns `req_valid` to low before the result is sampled. It moves the lockdown input only between requests. Between requests it leaves stale field values on the bus, so that the idle rule of R1 is exercised against non-zero fields.

// File: rtl/cmo_decoder.sv
module cmo_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [2:0]  req_op1,
  input  logic [3:0]  req_crm,
  input  logic [2:0]  req_op2,
  input  logic        req_is_read,
  input  logic        req_dual,
  input  logic        req_user,
  input  logic        req_nonsecure,
  input  logic        cfg_lock_secure,
  output logic [29:0] op_strobe,
  output logic [1:0]  op_fmt,
  output logic        op_undef,
  output logic        op_btc_flush
);
  localparam int NUM_OPS = 30;
  localparam int SELW    = $clog2(NUM_OPS);

  localparam logic [SELW-1:0] OP_INV_I_ALL  = 5'd0;
  localparam logic [SELW-1:0] OP_INV_I_MVA  = 5'd1;
  localparam logic [SELW-1:0] OP_INV_I_IDX  = 5'd2;
  localparam logic [SELW-1:0] OP_FLUSH_PFB  = 5'd3;
  localparam logic [SELW-1:0] OP_BTC_ALL    = 5'd4;
  localparam logic [SELW-1:0] OP_BTC_MVA    = 5'd5;
  localparam logic [SELW-1:0] OP_INV_D_ALL  = 5'd6;
  localparam logic [SELW-1:0] OP_INV_D_MVA  = 5'd7;
  localparam logic [SELW-1:0] OP_INV_D_IDX  = 5'd8;
  localparam logic [SELW-1:0] OP_INV_BOTH   = 5'd9;
  localparam logic [SELW-1:0] OP_CLN_D_ALL  = 5'd10;
  localparam logic [SELW-1:0] OP_CLN_D_MVA  = 5'd11;
  localparam logic [SELW-1:0] OP_CLN_D_IDX  = 5'd12;
  localparam logic [SELW-1:0] OP_SYNC_BAR   = 5'd13;
  localparam logic [SELW-1:0] OP_MEM_BAR    = 5'd14;
  localparam logic [SELW-1:0] OP_PF_I_MVA   = 5'd15;
  localparam logic [SELW-1:0] OP_CI_D_ALL   = 5'd16;
  localparam logic [SELW-1:0] OP_CI_D_MVA   = 5'd17;
  localparam logic [SELW-1:0] OP_CI_D_IDX   = 5'd18;
  localparam logic [SELW-1:0] OP_WAIT_IRQ   = 5'd19;
  localparam logic [SELW-1:0] OP_PAREG_WR   = 5'd20;
  localparam logic [SELW-1:0] OP_XL_CUR     = 5'd21;
  localparam logic [SELW-1:0] OP_XL_OTHER   = 5'd22;
  localparam logic [SELW-1:0] OP_RD_DIRTY   = 5'd23;
  localparam logic [SELW-1:0] OP_RD_PAREG   = 5'd24;
  localparam logic [SELW-1:0] OP_RNG_INV_I  = 5'd25;
  localparam logic [SELW-1:0] OP_RNG_INV_D  = 5'd26;
  localparam logic [SELW-1:0] OP_RNG_CLN_D  = 5'd27;
  localparam logic [SELW-1:0] OP_RNG_CI_D   = 5'd28;
  localparam logic [SELW-1:0] OP_NO_EFFECT  = 5'd29;

  localparam logic [1:0] FMT_SBZ = 2'd0;
  localparam logic [1:0] FMT_MVA = 2'd1;
  localparam logic [1:0] FMT_IDX = 2'd2;
  localparam logic [1:0] FMT_VA  = 2'd3;

  logic [SELW-1:0] sel;
  logic [1:0]      fmt;
  logic            hit, user_ok, ns_block, undef_c, btc_c;

  always_comb begin
    hit     = 1'b1;
    sel     = OP_NO_EFFECT;
    fmt     = FMT_SBZ;
    user_ok = 1'b0;
    if (req_dual) begin
      if (req_is_read) hit = 1'b0;
      else begin
        fmt = FMT_VA;
        case (req_crm)
          4'd5:  sel = OP_RNG_INV_I;
          4'd6:  sel = OP_RNG_INV_D;
          4'd12: begin sel = OP_RNG_CLN_D; user_ok = 1'b1; end
          4'd14: sel = OP_RNG_CI_D;
          default: fmt = FMT_SBZ;
        endcase
      end
    end else if (req_is_read) begin
      if (req_crm == 4'd10 && req_op2 == 3'd6)     sel = OP_RD_DIRTY;
      else if (req_crm == 4'd4 && req_op2 == 3'd0) sel = OP_RD_PAREG;
      else hit = 1'b0;
    end else begin
      case (req_crm)
        4'd0: if (req_op2 == 3'd4) sel = OP_WAIT_IRQ; else hit = 1'b0;
        4'd4: if (req_op2 == 3'd0) sel = OP_PAREG_WR; else hit = 1'b0;
        4'd5:
          case (req_op2)
            3'd0: sel = OP_INV_I_ALL;
            3'd1: begin sel = OP_INV_I_MVA; fmt = FMT_MVA; end
            3'd2: begin sel = OP_INV_I_IDX; fmt = FMT_IDX; end
            3'd4: begin sel = OP_FLUSH_PFB; user_ok = 1'b1; end
            3'd6: sel = OP_BTC_ALL;
            3'd7: begin sel = OP_BTC_MVA; fmt = FMT_MVA; end
            default: hit = 1'b0;
          endcase
        4'd6:
          case (req_op2)
            3'd0: sel = OP_INV_D_ALL;
            3'd1: begin sel = OP_INV_D_MVA; fmt = FMT_MVA; end
            3'd2: begin sel = OP_INV_D_IDX; fmt = FMT_IDX; end
            default: hit = 1'b0;
          endcase
        4'd7: if (req_op2 == 3'd0) sel = OP_INV_BOTH;
        4'd8: begin sel = req_op2[2] ? OP_XL_OTHER : OP_XL_CUR; fmt = FMT_VA; end
        4'd10:
          case (req_op2)
            3'd0: sel = OP_CLN_D_ALL;
            3'd1: begin sel = OP_CLN_D_MVA; fmt = FMT_MVA; end
            3'd2: begin sel = OP_CLN_D_IDX; fmt = FMT_IDX; end
            3'd4: begin sel = OP_SYNC_BAR; user_ok = 1'b1; end
            3'd5: begin sel = OP_MEM_BAR; user_ok = 1'b1; end
            default: hit = 1'b0;
          endcase
        4'd11, 4'd15: sel = OP_NO_EFFECT;
        4'd13: if (req_op2 == 3'd1) begin sel = OP_PF_I_MVA; fmt = FMT_MVA; end
               else hit = 1'b0;
        4'd14:
          case (req_op2)
            3'd0: sel = OP_CI_D_ALL;
            3'd1: begin sel = OP_CI_D_MVA; fmt = FMT_MVA; end
            3'd2: begin sel = OP_CI_D_IDX; fmt = FMT_IDX; end
            default: hit = 1'b0;
          endcase
        default: hit = 1'b0;
      endcase
    end
  end

  assign ns_block = req_nonsecure &&
                    (sel == OP_INV_D_ALL || sel == OP_INV_BOTH || sel == OP_XL_OTHER ||
                     (sel == OP_INV_I_ALL && cfg_lock_secure));
  assign undef_c  = !hit || (req_op1 != 3'd0) || (req_user && !user_ok) || ns_block;
  assign btc_c    = !undef_c && (sel == OP_INV_I_ALL || sel == OP_INV_BOTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_strobe    <= '0;
      op_fmt       <= FMT_SBZ;
      op_undef     <= 1'b0;
      op_btc_flush <= 1'b0;
    end else if (!req_valid) begin
      op_strobe    <= '0;
      op_fmt       <= FMT_SBZ;
      op_undef     <= 1'b0;
      op_btc_flush <= 1'b0;
    end else begin
      op_strobe    <= undef_c ? '0 : (NUM_OPS'(1) << sel);
      op_fmt       <= undef_c ? FMT_SBZ : fmt;
      op_undef     <= undef_c;
      op_btc_flush <= btc_c;
    end
  end
endmodule

// File: rtl/cmo_decoder_chk.sv
module cmo_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [2:0]  req_op1,
  input logic [3:0]  req_crm,
  input logic [2:0]  req_op2,
  input logic        req_is_read,
  input logic        req_dual,
  input logic        req_user,
  input logic        req_nonsecure,
  input logic        cfg_lock_secure,
  input logic [29:0] op_strobe,
  input logic [1:0]  op_fmt,
  input logic        op_undef,
  input logic        op_btc_flush
);
  localparam logic [29:0] USER_MASK = 30'h0800_6008;

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> $countones({op_strobe, op_undef}) == 1); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (op_strobe == '0 && !op_undef && !op_btc_flush)); // R1
  AST_RSVD_OP1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op1 != 3'd0) |=> op_undef); // R2
  AST_USER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_user) |=> (op_undef || (op_strobe & ~USER_MASK) == '0)); // R7
  AST_NS_INV_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_nonsecure && !req_dual && !req_is_read &&
     (req_crm == 4'd6 || req_crm == 4'd7) && req_op2 == 3'd0) |=> op_undef); // R8
  AST_OTHER_WORLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_nonsecure || req_user) && !req_dual && !req_is_read &&
     req_crm == 4'd8 && req_op2[2]) |=> op_undef); // R10
  AST_BTC_WITH_INV: assert property (@(posedge clk) disable iff (!rst_n)
    op_btc_flush |-> (op_strobe[0] || op_strobe[9])); // R12
  AST_INV_WITH_BTC: assert property (@(posedge clk) disable iff (!rst_n)
    (op_strobe[0] || op_strobe[9]) |-> op_btc_flush); // R12
  AST_UNDEF_FMT: assert property (@(posedge clk) disable iff (!rst_n)
    op_undef |-> op_fmt == 2'd0); // R13
endmodule

bind cmo_decoder cmo_decoder_chk u_chk (.*);

// File: tb/tb_cmo_decoder.sv
module tb_cmo_decoder;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op1 = '0;
  logic [3:0]  req_crm = '0;
  logic [2:0]  req_op2 = '0;
  logic        req_is_read = 1'b0;
  logic        req_dual = 1'b0;
  logic        req_user = 1'b0;
  logic        req_nonsecure = 1'b0;
  logic        cfg_lock_secure = 1'b0;
  logic [29:0] op_strobe;
  logic [1:0]  op_fmt;
  logic        op_undef;
  logic        op_btc_flush;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmo_decoder dut (.*);

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual {strobe,fmt,undef,btc}=%h expected %h", tag, act, exp);
    end
  endtask

  // issue one request; expect idx (or undef when exp_undef), format, btc
  task automatic run(input string tag, input logic [2:0] op1, input logic [3:0] crm,
                     input logic [2:0] op2, input logic rd, input logic dual,
                     input logic usr, input logic ns, input logic exp_undef,
                     input int idx, input logic [1:0] fmt, input logic btc);
    logic [29:0] es;
    @(negedge clk);
    req_valid = 1'b1; req_op1 = op1; req_crm = crm; req_op2 = op2;
    req_is_read = rd; req_dual = dual; req_user = usr; req_nonsecure = ns;
    @(negedge clk);
    req_valid = 1'b0;
    es = exp_undef ? 30'd0 : (30'd1 << idx);
    check(tag, {op_strobe, op_fmt, op_undef, op_btc_flush},
          {es, exp_undef ? 2'd0 : fmt, exp_undef, btc});
  endtask

  task automatic t_reset();
    check("R1 reset", {op_strobe, op_fmt, op_undef, op_btc_flush}, 34'd0);
  endtask

  task automatic t_writes();
    run("R3 R13 inv I mva",   0, 5, 1, 0,0,0,0, 0, 1, 1, 0);
    run("R3 R13 inv D idx",   0, 6, 2, 0,0,0,0, 0, 8, 2, 0);
    run("R3 clean D all",     0, 10,0, 0,0,0,0, 0, 10,0, 0);
    run("R3 R13 btc mva",     0, 5, 7, 0,0,0,0, 0, 5, 1, 0);
    run("R3 wait irq",        0, 0, 4, 0,0,0,0, 0, 19,0, 0);
    run("R3 R13 prefetch",    0, 13,1, 0,0,0,0, 0, 15,1, 0);
    run("R3 R13 ci D idx",    0, 14,2, 0,0,0,0, 0, 18,2, 0);
    run("R3 R13 xlate cur",   0, 8, 3, 0,0,0,0, 0, 21,3, 0);
    run("R3 xlate other sec", 0, 8, 6, 0,0,0,0, 0, 22,3, 0);
    run("R3 pa reg write",    0, 4, 0, 0,0,0,0, 0, 20,0, 0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    req_crm = 4'd5; req_op2 = 3'd0;
    @(negedge clk);
    check("R1 idle with stale fields", {op_strobe, op_fmt, op_undef, op_btc_flush}, 34'd0);
  endtask

  task automatic t_op1();
    run("R2 op1=1 valid enc",  1, 10,4, 0,0,0,0, 1, 0, 0, 0);
    run("R2 op1=7 read",       7, 4, 0, 1,0,0,0, 1, 0, 0, 0);
  endtask

  task automatic t_noeffect();
    run("R4 crm7 op2=3",   0, 7, 3, 0,0,0,0, 0, 29,0, 0);
    run("R4 crm11",        0, 11,5, 0,0,0,0, 0, 29,0, 0);
    run("R4 crm15",        0, 15,0, 0,0,0,0, 0, 29,0, 0);
  endtask

  task automatic t_unlisted();
    run("R5 dirty write",  0, 10,6, 0,0,0,0, 1, 0, 0, 0);
    run("R5 crm5 op2=3",   0, 5, 3, 0,0,0,0, 1, 0, 0, 0);
    run("R5 crm1",         0, 1, 0, 0,0,0,0, 1, 0, 0, 0);
    run("R5 crm13 op2=0",  0, 13,0, 0,0,0,0, 1, 0, 0, 0);
  endtask

  task automatic t_reads();
    run("R6 read dirty",   0, 10,6, 1,0,0,0, 0, 23,0, 0);
    run("R6 read pa",      0, 4, 0, 1,0,0,1, 0, 24,0, 0);
    run("R6 read crm5",    0, 5, 0, 1,0,0,0, 1, 0, 0, 0);
  endtask

  task automatic t_user();
    run("R7 user sync bar",   0, 10,4, 0,0,1,0, 0, 13,0, 0);
    run("R7 user mem bar",    0, 10,5, 0,0,1,1, 0, 14,0, 0);
    run("R7 user pfb flush",  0, 5, 4, 0,0,1,0, 0, 3, 0, 0);
    run("R7 user rng clean",  0, 12,0, 0,1,1,0, 0, 27,3, 0);
    run("R7 user inv D mva",  0, 6, 1, 0,0,1,0, 1, 0, 0, 0);
    run("R7 user read dirty", 0, 10,6, 1,0,1,0, 1, 0, 0, 0);
    run("R7 user no-effect",  0, 11,0, 0,0,1,0, 1, 0, 0, 0);
  endtask

  task automatic t_nonsecure();
    run("R8 ns inv D all",    0, 6, 0, 0,0,0,1, 1, 0, 0, 0);
    run("R8 ns inv both",     0, 7, 0, 0,0,0,1, 1, 0, 0, 0);
    run("R8 ns inv D mva ok", 0, 6, 1, 0,0,0,1, 0, 7, 1, 0);
    @(negedge clk); cfg_lock_secure = 1'b1;
    run("R9 ns inv I locked", 0, 5, 0, 0,0,0,1, 1, 0, 0, 0);
    run("R9 R12 sec inv I locked", 0, 5, 0, 0,0,0,0, 0, 0, 0, 1);
    @(negedge clk); cfg_lock_secure = 1'b0;
    run("R9 R12 ns inv I free", 0, 5, 0, 0,0,0,1, 0, 0, 0, 1);
  endtask

  task automatic t_translate();
    run("R10 ns other world",   0, 8, 4, 0,0,0,1, 1, 0, 0, 0);
    run("R10 user other world", 0, 8, 7, 0,0,1,0, 1, 0, 0, 0);
    run("R10 ns current ok",    0, 8, 1, 0,0,0,1, 0, 21,3, 0);
  endtask

  task automatic t_dual();
    run("R11 rng inv I",    0, 5, 0, 0,1,0,0, 0, 25,3, 0);
    run("R11 rng inv D",    0, 6, 3, 0,1,0,0, 0, 26,3, 0);
    run("R11 rng ci D",     0, 14,0, 0,1,0,0, 0, 28,3, 0);
    run("R11 rng other",    0, 9, 0, 0,1,0,0, 0, 29,0, 0);
    run("R11 rng read",     0, 5, 0, 1,1,0,0, 1, 0, 0, 0);
    run("R11 R12 rng not btc", 0, 7, 0, 0,1,0,0, 0, 29,0, 0);
  endtask

  task automatic t_btc();
    run("R12 inv both",     0, 7, 0, 0,0,0,0, 0, 9, 0, 1);
    run("R12 btc flush all no global", 0, 5, 6, 0,0,0,0, 0, 4, 0, 0);
    run("R12 R13 ci D all", 0, 14,0, 0,0,0,0, 0, 16,0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_writes();
    t_idle();
    t_op1();
    t_noeffect();
    t_unlisted();
    t_reads();
    t_user();
    t_nonsecure();
    t_translate();
    t_dual();
    t_btc();
    t_idle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule